// File: doc/BRIEF.md
# Associative Tag-Match Lookup Memory

This block is a small content-addressable store of `LINES` entries. Each entry holds a `TAG_W`-bit key, a `DATA_W`-bit word and a valid bit. During a lookup, the presented key goes to one equality comparator per entry, and all entries are compared in the same cycle. The block returns three results: a per-entry hit vector, a combined hit flag, and the word of the matching entry. That word is formed as the bitwise OR of every entry's word, each gated by its own hit bit. There is no priority encoder and no multiplexer.

Two enables pick the operation each cycle:

| `key_enable` | `word_enable` | Mode | Action |
|---|---|---|---|
| 0 | 0 | `OP_WRITE` | Stores a key/word pair into the entry named by `wr_index`. |
| 1 | 1 | `OP_LOOKUP` | Runs the associative search. |
| mixed | mixed | `OP_IDLE` | Nothing is stored and no result is updated. |

The control decoder moves freely from any mode to any mode on each cycle's enables. There are no other transitions.

The key input serves both operations, so a single comparator bank serves both. During a lookup it finds the match. During a write it finds any other entry already holding the key being written, and the block invalidates that entry. This keeps every key in at most one entry, which keeps the OR-combined word well defined. A separate multi-hit flag reports any breach of that rule.

Top module: `assoc_tag_lookup`

## Requirements
- R1: A synchronous active-low reset clears every valid bit and drives `line_hit`, `any_hit`, `multi_hit` and `word_out` to zero. After reset, no lookup hits, even for key zero.
- R2: With both enables low, the entry selected by `wr_index` takes `key_in` and `word_in` at the rising edge and becomes valid.
- R3: With both enables high, the lookup is registered. Bit i of `line_hit` becomes 1 exactly when entry i is valid and its stored key equals `key_in`. The result appears after that rising edge and not before it, giving a latency of one cycle.
- R4: `any_hit` is the OR of all `line_hit` bits of the same result.
- R5: `word_out` is the bitwise OR of the words of all hitting entries. It is all zeros when no entry hits.
- R6: A write whose key equals the key of another valid entry invalidates that other entry. At most one `line_hit` bit is ever set.
- R7: `multi_hit` is 1 when more than one `line_hit` bit is set. Because of R6 it stays 0.
- R8: Mixed enables (one high, one low) change no stored entry, and `line_hit`, `any_hit`, `word_out` and `multi_hit` hold their values.
- R9: A write cycle leaves the lookup outputs unchanged.
- R10: Writing a new key to an entry replaces its old key. A later lookup of the old key misses, unless another entry holds that key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_enable | input | 1 | Key-side enable: low to write, high to look up |
| word_enable | input | 1 | Word-side enable: low to write, high to look up |
| wr_index | input | IDX_W | Entry written when both enables are low |
| key_in | input | TAG_W | Key to store or to search for |
| word_in | input | DATA_W | Word stored on a write |
| line_hit | output | LINES | Registered per-entry match vector |
| any_hit | output | 1 | Registered OR of the per-entry matches |
| multi_hit | output | 1 | Registered flag for more than one match |
| word_out | output | DATA_W | Registered OR of the match-gated words |

## Verification
Every lookup result is due exactly one rising edge after the cycle in which both enables are high. The bench therefore drives inputs on the falling edge. It checks a quarter period later that the old result is still present, and checks the new result at the next falling edge.

A write takes effect at the next rising edge. Its effect is observed through a later lookup, and the lookup outputs are compared before and after each write or mixed-enable cycle to confirm they hold. Duplicate-key writes, overwrites of an entry, the last entry index, key zero after reset, and a lookup that misses each have their own expected values, computed from a model kept in the bench.

// File: rtl/atl_pkg.sv
package atl_pkg;

    // Operation selected each cycle by the two enables.
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_LOOKUP = 2'd2
    } atl_op_e;

endpackage

// File: rtl/atl_ctrl.sv
module atl_ctrl
    import atl_pkg::*;
(
    input  logic key_enable,
    input  logic word_enable,
    output logic wr_go,
    output logic rd_go
);

    atl_op_e op;

    // Mode decode: both low writes, both high looks up, mixed idles.
    always_comb begin
        unique case ({key_enable, word_enable})
            2'b00:   op = OP_WRITE;
            2'b11:   op = OP_LOOKUP;
            default: op = OP_IDLE;
        endcase
    end

    // Per-mode strobes.
    always_comb begin
        wr_go = 1'b0;
        rd_go = 1'b0;
        unique case (op)
            OP_WRITE:  wr_go = 1'b1;
            OP_LOOKUP: rd_go = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/atl_line_store.sv
module atl_line_store #(
    parameter int LINES  = 8,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_go,
    input  logic [IDX_W-1:0]              wr_index,
    input  logic [TAG_W-1:0]              key_in,
    input  logic [DATA_W-1:0]             word_in,
    output logic [LINES-1:0]              line_match,
    output logic [LINES-1:0][DATA_W-1:0]  line_word
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] word;
        logic              sel;

        assign sel = (wr_index == IDX_W'(g));

        // Compare: every key bit must agree (XNOR, then AND-reduce).
        assign line_match[g] = vld & (&(~(tag ^ key_in)));
        assign line_word[g]  = word;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld  <= 1'b0;
                tag  <= '0;
                word <= '0;
            end else if (wr_go) begin
                if (sel) begin
                    vld  <= 1'b1;
                    tag  <= key_in;
                    word <= word_in;
                end else if (line_match[g]) begin
                    // Same key elsewhere: drop it to keep keys unique.
                    vld  <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/atl_match_combine.sv
module atl_match_combine #(
    parameter int LINES  = 8,
    parameter int DATA_W = 16
) (
    input  logic [LINES-1:0]             line_match,
    input  logic [LINES-1:0][DATA_W-1:0] line_word,
    output logic [DATA_W-1:0]            gated_word,
    output logic                         any_match,
    output logic                         many_match
);

    always_comb begin
        logic seen;
        gated_word = '0;
        any_match  = 1'b0;
        many_match = 1'b0;
        seen       = 1'b0;
        for (int i = 0; i < LINES; i++) begin
            gated_word = gated_word | (line_word[i] & {DATA_W{line_match[i]}});
            any_match  = any_match | line_match[i];
            many_match = many_match | (seen & line_match[i]);
            seen       = seen | line_match[i];
        end
    end

endmodule

// File: rtl/assoc_tag_lookup.sv
module assoc_tag_lookup #(
    parameter int LINES  = 8,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_enable,
    input  logic              word_enable,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [TAG_W-1:0]  key_in,
    input  logic [DATA_W-1:0] word_in,
    output logic [LINES-1:0]  line_hit,
    output logic              any_hit,
    output logic              multi_hit,
    output logic [DATA_W-1:0] word_out
);

    logic                         wr_go;
    logic                         rd_go;
    logic [LINES-1:0]             line_match;
    logic [LINES-1:0][DATA_W-1:0] line_word;
    logic [DATA_W-1:0]            gated_word;
    logic                         any_match;
    logic                         many_match;

    logic [LINES-1:0]  hit_q;
    logic              any_q;
    logic              multi_q;
    logic [DATA_W-1:0] word_q;

    atl_ctrl i_ctrl (
        .key_enable  (key_enable),
        .word_enable (word_enable),
        .wr_go       (wr_go),
        .rd_go       (rd_go)
    );

    atl_line_store #(
        .LINES  (LINES),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_go      (wr_go),
        .wr_index   (wr_index),
        .key_in     (key_in),
        .word_in    (word_in),
        .line_match (line_match),
        .line_word  (line_word)
    );

    atl_match_combine #(
        .LINES  (LINES),
        .DATA_W (DATA_W)
    ) i_combine (
        .line_match (line_match),
        .line_word  (line_word),
        .gated_word (gated_word),
        .any_match  (any_match),
        .many_match (many_match)
    );

    // Result registers: loaded only by a lookup, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q   <= '0;
            any_q   <= 1'b0;
            multi_q <= 1'b0;
            word_q  <= '0;
        end else if (rd_go) begin
            hit_q   <= line_match;
            any_q   <= any_match;
            multi_q <= many_match;
            word_q  <= gated_word;
        end
    end

    assign line_hit  = hit_q;
    assign any_hit   = any_q;
    assign multi_hit = multi_q;
    assign word_out  = word_q;

endmodule

// File: rtl/atl_checker.sv
module atl_checker #(
    parameter int LINES  = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              key_enable,
    input logic              word_enable,
    input logic [LINES-1:0]  line_hit,
    input logic              any_hit,
    input logic              multi_hit,
    input logic [DATA_W-1:0] word_out
);

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (line_hit == '0 && !any_hit && word_out == '0)); // R1

    AST_ANY_FROM_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit == (|line_hit)); // R4

    AST_MISS_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |-> word_out == '0); // R5

    AST_SINGLE_LINE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(line_hit)); // R6

    AST_NO_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
        !multi_hit && (multi_hit == ($countones(line_hit) > 1))); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_enable != word_enable) |=>
            ($stable(line_hit) && $stable(any_hit) && $stable(word_out) && $stable(multi_hit))); // R8

    AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_enable && !word_enable) |=>
            ($stable(line_hit) && $stable(any_hit) && $stable(word_out))); // R9

endmodule

bind assoc_tag_lookup atl_checker #(
    .LINES  (LINES),
    .DATA_W (DATA_W)
) i_atl_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_enable  (key_enable),
    .word_enable (word_enable),
    .line_hit    (line_hit),
    .any_hit     (any_hit),
    .multi_hit   (multi_hit),
    .word_out    (word_out)
);

// File: tb/test_assoc_tag_lookup.sv
module test_assoc_tag_lookup;

    localparam int CLK_PERIOD = 10;
    localparam int LINES  = 8;
    localparam int TAG_W  = 8;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              key_enable = 1'b1;
    logic              word_enable = 1'b0;
    logic [IDX_W-1:0]  wr_index = '0;
    logic [TAG_W-1:0]  key_in = '0;
    logic [DATA_W-1:0] word_in = '0;
    logic [LINES-1:0]  line_hit;
    logic              any_hit;
    logic              multi_hit;
    logic [DATA_W-1:0] word_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Model kept from the requirements.
    logic              m_vld [LINES];
    logic [TAG_W-1:0]  m_tag [LINES];
    logic [DATA_W-1:0] m_word[LINES];

    always #(CLK_PERIOD/2) clk = ~clk;

    assoc_tag_lookup #(
        .LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) i_assoc_tag_lookup (
        .clk(clk), .rst_n(rst_n), .key_enable(key_enable), .word_enable(word_enable),
        .wr_index(wr_index), .key_in(key_in), .word_in(word_in),
        .line_hit(line_hit), .any_hit(any_hit), .multi_hit(multi_hit), .word_out(word_out)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic go_idle();
        key_enable  = 1'b1;
        word_enable = 1'b0;
    endtask

    // Write (R2 and R6 semantics in the model); outputs must hold (R9).
    task automatic do_write(input int idx, input logic [TAG_W-1:0] k, input logic [DATA_W-1:0] w);
        logic [LINES-1:0]  h0 = line_hit;
        logic [DATA_W-1:0] w0 = word_out;
        @(negedge clk);
        key_enable = 1'b0; word_enable = 1'b0;
        wr_index = IDX_W'(idx); key_in = k; word_in = w;
        @(negedge clk);
        go_idle();
        for (int j = 0; j < LINES; j++)
            if (j != idx && m_vld[j] && m_tag[j] == k) m_vld[j] = 1'b0;
        m_vld[idx] = 1'b1; m_tag[idx] = k; m_word[idx] = w;
        check("R9", "line_hit after write", 32'(line_hit), 32'(h0));
        check("R9", "word_out after write", 32'(word_out), 32'(w0));
    endtask

    // Lookup with latency check (R3) and result checks (R3, R4, R5, R7).
    task automatic do_lookup(input logic [TAG_W-1:0] k, input string req);
        logic [LINES-1:0]  h0 = line_hit;
        logic [DATA_W-1:0] w0 = word_out;
        logic [LINES-1:0]  eh = '0;
        logic [DATA_W-1:0] ew = '0;
        @(negedge clk);
        key_enable = 1'b1; word_enable = 1'b1; key_in = k;
        #(CLK_PERIOD/4);
        check("R3", "line_hit before edge", 32'(line_hit), 32'(h0));
        check("R3", "word_out before edge", 32'(word_out), 32'(w0));
        @(negedge clk);
        go_idle();
        for (int j = 0; j < LINES; j++)
            if (m_vld[j] && m_tag[j] == k) begin
                eh[j] = 1'b1;
                ew    = ew | m_word[j];
            end
        check(req,  "line_hit", 32'(line_hit), 32'(eh));
        check("R4", "any_hit",  32'(any_hit), 32'(|eh));
        check("R5", "word_out", 32'(word_out), 32'(ew));
        check("R7", "multi_hit", 32'(multi_hit), 32'(0));
    endtask

    task automatic t_reset_state();
        for (int j = 0; j < LINES; j++) begin
            m_vld[j] = 1'b0; m_tag[j] = '0; m_word[j] = '0;
        end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", "line_hit at reset", 32'(line_hit), 32'(0));
        check("R1", "any_hit at reset", 32'(any_hit), 32'(0));
        check("R1", "word_out at reset", 32'(word_out), 32'(0));
        do_lookup(8'h00, "R1");
    endtask

    task automatic t_basic();
        do_write(0, 8'h11, 16'hA001);
        do_write(3, 8'h33, 16'hB003);
        do_write(LINES-1, 8'h77, 16'hC007);
        do_lookup(8'h33, "R2");
        do_lookup(8'h11, "R3");
        do_lookup(8'h77, "R2");
        do_lookup(8'h5A, "R5");
    endtask

    task automatic t_fill_all();
        for (int i = 0; i < LINES; i++)
            do_write(i, TAG_W'(8'h80 + i), DATA_W'(16'h1000 + i * 16'h0111));
        for (int i = LINES - 1; i >= 0; i--)
            do_lookup(TAG_W'(8'h80 + i), "R3");
    endtask

    task automatic t_duplicate();
        do_write(2, 8'hD5, 16'h0F0F);
        do_write(5, 8'hD5, 16'hF0F0);
        do_lookup(8'hD5, "R6");
        check("R6", "hit is entry 5 only", 32'(line_hit), 32'(8'b0010_0000));
        check("R6", "word from entry 5", 32'(word_out), 32'(16'hF0F0));
    endtask

    task automatic t_overwrite();
        do_write(4, 8'h44, 16'h4444);
        do_lookup(8'h44, "R10");
        do_write(4, 8'h45, 16'h4545);
        do_lookup(8'h44, "R10");
        check("R10", "old key misses", 32'(any_hit), 32'(0));
        do_lookup(8'h45, "R10");
    endtask

    task automatic t_idle_mixed();
        logic [LINES-1:0]  h0;
        logic [DATA_W-1:0] w0;
        do_lookup(8'h45, "R8");
        h0 = line_hit; w0 = word_out;
        @(negedge clk);
        key_enable = 1'b0; word_enable = 1'b1;
        wr_index = 3'd6; key_in = 8'hE6; word_in = 16'hE6E6;
        @(negedge clk);
        key_enable = 1'b1; word_enable = 1'b0; key_in = 8'h33;
        @(negedge clk);
        go_idle();
        check("R8", "line_hit held", 32'(line_hit), 32'(h0));
        check("R8", "word_out held", 32'(word_out), 32'(w0));
        do_lookup(8'hE6, "R8");
        check("R8", "mixed enables stored nothing", 32'(any_hit), 32'(0));
    endtask

    initial begin
        t_reset_state();
        t_basic();
        t_fill_all();
        t_duplicate();
        t_overwrite();
        t_idle_mixed();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule